// File: doc/BRIEF.md
# Boost Regulator Startup and Fault Sequencer

This block is the control state machine of a synchronous boost converter. It brings the output up from shutdown in stages. First a linear precharge runs at a low current step, then at a higher one. Next comes a soft-start phase with a reduced current limit and a stepping reference. The machine then settles in boost or in bypass. It watches a set of fault conditions, parks in a fault state with switching stopped and the input-to-output path blocked, and retries automatically after a fixed wait.

All analog sensing arrives as single-bit comparator flags. Every timeout counts a free-running microsecond tick, so the time limits are set in tick units. A single timer serves every state and restarts whenever the state changes. The outputs drive the precharge current source, the current-limit scaling, the reference stepper, the switching modulator and the pass switches.

Top module: `boost_seq_top`

## Requirements
- R1: After reset the state code is 0. The codes are 0 off, 1 precharge step one, 2 precharge step two, 3 soft-start, 4 boost, 5 bypass and 6 fault; code 7 never appears.
- R2: In state 0, with enable high, the undervoltage-OK flag high and no thermal request, the next edge enters state 1. The precharge level output is 1 in state 1, 2 in state 2 and 0 elsewhere.
- R3: In state 1 the near-input flag moves the block to state 3. If the flag stays low, the 512th tick counted from entry moves it to state 2.
- R4: In state 2 the near-input flag moves the block to state 3. If the flag stays low, the 1024th tick counted from entry moves it to state 6.
- R5: In state 3 the current-limit halving and the switching enable are high. The reference-step output equals step-reached AND tick. If the target flag stays low, the 64th tick moves the block to state 6.
- R6: In state 3 a high target flag ends soft-start. The block enters state 4 when the input-above-target flag is low and state 5 when it is high.
- R7: State 4 goes to state 5 when the input-above-target flag is high. State 5 goes back to state 4 when that flag is low. In state 5 the bypass-fault request moves the block to state 6.
- R8: In state 4, a valley-limit flag that stays high on 2 consecutive ticks moves the block to state 6. A cycle with the flag low restarts that count.
- R9: In any of states 1 to 5, a low undervoltage-OK flag or a thermal request moves the block to state 6 on the next edge.
- R10: In state 6 switching is disabled and the path-blocked output is high. The 20th tick after entry moves the block to state 0, from which startup repeats.
- R11: A low enable returns the block to state 0 on the next edge from any state. State 0 blocks the path and disables switching.
- R12: The timer restarts on every state change, so ticks spent in an earlier state never shorten a later timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| uvlo_ok_i | input | 1 | Input supply above undervoltage lockout |
| near_vin_i | input | 1 | Output within 300 mV of the input |
| step_ok_i | input | 1 | Output has reached the present soft-start reference step |
| at_target_i | input | 1 | Output at its target |
| vin_above_i | input | 1 | Input above the output target |
| vlim_i | input | 1 | Valley current limit active |
| therm_i | input | 1 | Thermal shutdown request |
| byp_flt_i | input | 1 | Bypass drop fault request |
| tick_i | input | 1 | One-microsecond time base pulse |
| state_o | output | 3 | State code |
| pre_lvl_o | output | 2 | Precharge current level (0 off, 1 low, 2 high) |
| ilim_half_o | output | 1 | Halve the valley current limit |
| ref_step_o | output | 1 | Advance the internal reference by one step |
| sw_en_o | output | 1 | Modulator switching enable |
| path_block_o | output | 1 | Input-to-output path blocked |

## Verification
The hardest condition to reach from the ports is the fault entered from the second precharge step. It needs a full 512-tick first step followed by a 1024-tick second step, all with the near-input flag held low. The stimulus runs the tick on every cycle and samples one cycle before and one cycle after each limit. The retry wait is then checked the same way. The valley-limit persistence check inserts a one-cycle gap between two single-tick assertions of the flag, to show that the count restarts.

// File: rtl/boost_seq_pkg.sv
// Package: shared state codes and precharge level codes for the sequencer.
// Assumes: 3-bit state code, whose values are visible at the top-level port.
package boost_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_PRE1 = 3'd1,
        ST_PRE2 = 3'd2,
        ST_SOFT = 3'd3,
        ST_RUN  = 3'd4,
        ST_PASS = 3'd5,
        ST_FLT  = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        PRE_NONE = 2'd0,
        PRE_LOW  = 2'd1,
        PRE_HIGH = 2'd2
    } pre_lvl_e;

endpackage

// File: rtl/seq_timer.sv
// Module: single shared tick counter for all sequencer timeouts.
// Assumes: the caller raises clr on every state change; the counter saturates.
module seq_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count ticks, restarting on clear and holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/seq_fsm.sv
// Module: next-state logic and state register of the startup and fault sequencer.
// Assumes: all flags are synchronous to clk; the limits are counted in ticks from state entry.
module seq_fsm
    import boost_seq_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int PRE1_TICKS  = 512,
    parameter int PRE2_TICKS  = 1024,
    parameter int SOFT_TICKS  = 64,
    parameter int VLIM_TICKS  = 2,
    parameter int RETRY_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             uvlo_ok_i,
    input  logic             near_vin_i,
    input  logic             at_target_i,
    input  logic             vin_above_i,
    input  logic             vlim_i,
    input  logic             therm_i,
    input  logic             byp_flt_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    output seq_state_e       state_o,
    output logic             tmr_clr_o,
    output logic             tmr_inc_o
);
    localparam logic [CNT_W-1:0] PRE1_LAST  = CNT_W'(PRE1_TICKS - 1);
    localparam logic [CNT_W-1:0] PRE2_LAST  = CNT_W'(PRE2_TICKS - 1);
    localparam logic [CNT_W-1:0] SOFT_LAST  = CNT_W'(SOFT_TICKS - 1);
    localparam logic [CNT_W-1:0] VLIM_LAST  = CNT_W'(VLIM_TICKS - 1);
    localparam logic [CNT_W-1:0] RETRY_LAST = CNT_W'(RETRY_TICKS - 1);

    seq_state_e st_q, st_d;
    logic       active;
    logic       hard_flt;

    // Classify the present state and the faults common to all active states.
    always_comb begin
        active   = (st_q == ST_PRE1) || (st_q == ST_PRE2) || (st_q == ST_SOFT) ||
                   (st_q == ST_RUN)  || (st_q == ST_PASS);
        hard_flt = !uvlo_ok_i || therm_i;
    end

    // Choose the next state: enable first, then common faults, then per-state moves.
    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = ST_OFF;
        end else if (active && hard_flt) begin
            st_d = ST_FLT;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    if (uvlo_ok_i && !therm_i)
                        st_d = ST_PRE1;
                end
                ST_PRE1: begin
                    if (near_vin_i)
                        st_d = ST_SOFT;
                    else if (tick_i && cnt_i == PRE1_LAST)
                        st_d = ST_PRE2;
                end
                ST_PRE2: begin
                    if (near_vin_i)
                        st_d = ST_SOFT;
                    else if (tick_i && cnt_i == PRE2_LAST)
                        st_d = ST_FLT;
                end
                ST_SOFT: begin
                    if (at_target_i)
                        st_d = vin_above_i ? ST_PASS : ST_RUN;
                    else if (tick_i && cnt_i == SOFT_LAST)
                        st_d = ST_FLT;
                end
                ST_RUN: begin
                    if (vlim_i && tick_i && cnt_i == VLIM_LAST)
                        st_d = ST_FLT;
                    else if (vin_above_i)
                        st_d = ST_PASS;
                end
                ST_PASS: begin
                    if (byp_flt_i)
                        st_d = ST_FLT;
                    else if (!vin_above_i)
                        st_d = ST_RUN;
                end
                ST_FLT: begin
                    if (tick_i && cnt_i == RETRY_LAST)
                        st_d = ST_OFF;
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    // Timer control: restart on a state change, and in boost whenever the limit flag drops.
    always_comb begin
        tmr_clr_o = (st_d != st_q) || (st_q == ST_RUN && !vlim_i);
        tmr_inc_o = tick_i;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_OFF;
        else
            st_q <= st_d;
    end

    assign state_o = st_q;

    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 3'd7);

    assert_en_low_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> st_q == ST_OFF);

    assert_supply_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && active && (!uvlo_ok_i || therm_i)) |=> st_q == ST_FLT);

    assert_soft_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !hard_flt && st_q == ST_SOFT && !at_target_i && tick_i && cnt_i == SOFT_LAST)
        |=> st_q == ST_FLT);

endmodule

// File: rtl/seq_outdrv.sv
// Module: decodes the sequencer state into the actuator controls.
// Assumes: purely combinational; the reference step is qualified by the tick.
module seq_outdrv
    import boost_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       step_ok_i,
    input  logic       tick_i,
    output logic [1:0] pre_lvl_o,
    output logic       ilim_half_o,
    output logic       ref_step_o,
    output logic       sw_en_o,
    output logic       path_block_o
);
    // Map each state to its precharge level, switching and path controls.
    always_comb begin
        pre_lvl_o    = PRE_NONE;
        ilim_half_o  = 1'b0;
        ref_step_o   = 1'b0;
        sw_en_o      = 1'b0;
        path_block_o = 1'b0;
        unique case (state_i)
            ST_OFF:  path_block_o = 1'b1;
            ST_PRE1: pre_lvl_o = PRE_LOW;
            ST_PRE2: pre_lvl_o = PRE_HIGH;
            ST_SOFT: begin
                ilim_half_o = 1'b1;
                sw_en_o     = 1'b1;
                ref_step_o  = step_ok_i && tick_i;
            end
            ST_RUN:  sw_en_o = 1'b1;
            ST_PASS: sw_en_o = 1'b0;
            ST_FLT:  path_block_o = 1'b1;
            default: path_block_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/boost_seq_top.sv
// Module: startup and fault sequencer of a boost regulator (top level).
// Assumes: flags are already synchronised; tick_i is a one-cycle pulse per microsecond.
module boost_seq_top
    import boost_seq_pkg::*;
#(
    parameter int PRE1_TICKS  = 512,
    parameter int PRE2_TICKS  = 1024,
    parameter int SOFT_TICKS  = 64,
    parameter int VLIM_TICKS  = 2,
    parameter int RETRY_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       uvlo_ok_i,
    input  logic       near_vin_i,
    input  logic       step_ok_i,
    input  logic       at_target_i,
    input  logic       vin_above_i,
    input  logic       vlim_i,
    input  logic       therm_i,
    input  logic       byp_flt_i,
    input  logic       tick_i,
    output logic [2:0] state_o,
    output logic [1:0] pre_lvl_o,
    output logic       ilim_half_o,
    output logic       ref_step_o,
    output logic       sw_en_o,
    output logic       path_block_o
);
    localparam int MAX_A = (PRE1_TICKS > PRE2_TICKS) ? PRE1_TICKS : PRE2_TICKS;
    localparam int MAX_B = (SOFT_TICKS > RETRY_TICKS) ? SOFT_TICKS : RETRY_TICKS;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > VLIM_TICKS) ? MAX_C : VLIM_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             tmr_clr;
    logic             tmr_inc;

    seq_fsm #(
        .CNT_W      (CNT_W),
        .PRE1_TICKS (PRE1_TICKS),
        .PRE2_TICKS (PRE2_TICKS),
        .SOFT_TICKS (SOFT_TICKS),
        .VLIM_TICKS (VLIM_TICKS),
        .RETRY_TICKS(RETRY_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .uvlo_ok_i  (uvlo_ok_i),
        .near_vin_i (near_vin_i),
        .at_target_i(at_target_i),
        .vin_above_i(vin_above_i),
        .vlim_i     (vlim_i),
        .therm_i    (therm_i),
        .byp_flt_i  (byp_flt_i),
        .tick_i     (tick_i),
        .cnt_i      (cnt),
        .state_o    (st),
        .tmr_clr_o  (tmr_clr),
        .tmr_inc_o  (tmr_inc)
    );

    seq_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .inc  (tmr_inc),
        .cnt  (cnt)
    );

    seq_outdrv u_drv (
        .state_i     (st),
        .step_ok_i   (step_ok_i),
        .tick_i      (tick_i),
        .pre_lvl_o   (pre_lvl_o),
        .ilim_half_o (ilim_half_o),
        .ref_step_o  (ref_step_o),
        .sw_en_o     (sw_en_o),
        .path_block_o(path_block_o)
    );

    assign state_o = st;

    assert_timer_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st != $past(st)) |-> cnt == '0);

    assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLT) |-> (!sw_en_o && path_block_o));

    assert_half_only_soft_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_half_o |-> st == ST_SOFT);

    assert_off_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |-> (path_block_o && !sw_en_o && pre_lvl_o == 2'd0));

endmodule

// File: tb/sim_boost_seq_top.sv
module sim_boost_seq_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en, uvlo, near, step, tgt, above, vlim, therm, bflt, tick;
    logic [2:0] state;
    logic [1:0] pre_lvl;
    logic ilim_half, ref_step, sw_en, path_block;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boost_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_ok_i(uvlo), .near_vin_i(near),
        .step_ok_i(step), .at_target_i(tgt), .vin_above_i(above), .vlim_i(vlim),
        .therm_i(therm), .byp_flt_i(bflt), .tick_i(tick),
        .state_o(state), .pre_lvl_o(pre_lvl), .ilim_half_o(ilim_half),
        .ref_step_o(ref_step), .sw_en_o(sw_en), .path_block_o(path_block)
    );

    // Vector bits: en uvlo near tgt above vlim therm bflt | expected state after one edge.
    localparam logic [10:0] VEC [16] = '{
        11'b11_000000_001,  // R2 start
        11'b11_100000_011,  // R3 near -> soft
        11'b11_010000_100,  // R6 target, input low -> boost
        11'b11_001000_101,  // R7 boost -> bypass
        11'b11_000000_100,  // R7 bypass -> boost
        11'b11_001000_101,  // R7 boost -> bypass
        11'b11_001001_110,  // R7 bypass fault
        11'b00_000000_000,  // R11 enable low
        11'b11_000000_001,  // R2 restart
        11'b10_000000_110,  // R9 undervoltage
        11'b00_000000_000,  // R11
        11'b11_000000_001,  // R2
        11'b11_000010_110,  // R9 thermal
        11'b01_000000_000,  // R11 enable low from fault
        11'b11_000010_000,  // R2 thermal blocks start
        11'b11_000000_001   // R2
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_state(input int exp, input string req);
        chk(state == 3'(exp), req, state, exp);
    endtask

    // Expected decoded outputs per state, taken from the requirements.
    task automatic chk_outs(input int s, input string req);
        int ep = (s == 1) ? 1 : (s == 2) ? 2 : 0;
        chk(pre_lvl == 2'(ep), {req, " pre_lvl"}, pre_lvl, ep);
        chk(ilim_half == (s == 3), {req, " ilim_half"}, ilim_half, int'(s == 3));
        chk(sw_en == (s == 3 || s == 4), {req, " sw_en"}, sw_en, int'(s == 3 || s == 4));
        chk(path_block == (s == 0 || s == 6), {req, " path_block"}, path_block,
            int'(s == 0 || s == 6));
    endtask

    task automatic idle_in();
        en = 0; uvlo = 0; near = 0; step = 0; tgt = 0; above = 0;
        vlim = 0; therm = 0; bflt = 0; tick = 0;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 200000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        idle_in();
        cyc(3);
        rst_n = 1'b1;
        #1;
        chk_state(0, "R1 reset");
        chk_outs(0, "R11 reset");

        // Table walk, tick held low.
        for (int i = 0; i < 16; i++) begin
            {en, uvlo, near, tgt, above, vlim, therm, bflt} = VEC[i][10:3];
            cyc(1);
            chk_state(int'(VEC[i][2:0]), "R7 vector");
            chk_outs(int'(VEC[i][2:0]), "R5 vector");
        end

        // R3/R4/R10: full precharge timeouts and retry, tick every cycle.
        idle_in(); cyc(1);
        en = 1; uvlo = 1; tick = 1;
        cyc(1);
        chk_state(1, "R2 entry");
        cyc(511);
        chk_state(1, "R3 before limit");
        cyc(1);
        chk_state(2, "R3 step two");
        chk_outs(2, "R2 high level");
        cyc(1023);
        chk_state(2, "R4 before limit");
        cyc(1);
        chk_state(6, "R4 timeout fault");
        chk_outs(6, "R10 fault outputs");
        cyc(19);
        chk_state(6, "R10 before retry");
        cyc(1);
        chk_state(0, "R10 retry off");
        cyc(1);
        chk_state(1, "R10 restart");

        // R12/R5: ticks in step one do not count toward soft-start.
        cyc(5);
        near = 1; cyc(1); near = 0;
        chk_state(3, "R3 near in step one");
        tick = 0; step = 1; #1;
        chk(ref_step == 1'b0, "R5 ref step no tick", ref_step, 0);
        tick = 1; #1;
        chk(ref_step == 1'b1, "R5 ref step", ref_step, 1);
        step = 0; #1;
        chk(ref_step == 1'b0, "R5 ref step no flag", ref_step, 0);
        cyc(63);
        chk_state(3, "R12 soft before limit");
        cyc(1);
        chk_state(6, "R5 soft timeout");

        // R6: soft-start directly to bypass.
        en = 0; cyc(1); en = 1; cyc(1);
        near = 1; cyc(1); near = 0;
        tgt = 1; above = 1; cyc(1); tgt = 0;
        chk_state(5, "R6 soft to bypass");
        chk_outs(5, "R7 bypass outputs");

        // R8: valley limit persistence in boost.
        above = 0; cyc(1);
        chk_state(4, "R7 back to boost");
        vlim = 1; cyc(1);
        vlim = 0; cyc(1);
        chk_state(4, "R8 gap restarts count");
        vlim = 1; cyc(1);
        chk_state(4, "R8 one tick");
        cyc(1);
        chk_state(6, "R8 limit fault");

        // R11: enable low from boost.
        vlim = 0; en = 0; cyc(1); en = 1; cyc(1);
        near = 1; cyc(1); near = 0; tgt = 1; cyc(1); tgt = 0;
        chk_state(4, "R6 soft to boost");
        en = 0; cyc(1);
        chk_state(0, "R11 boost to off");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule